// File: doc/BRIEF.md
# Bayer Defect Pixel Corrector

This block sits in a raw image pipeline and repairs isolated bad pixels in a stream of 10-bit Bayer samples as they pass. Each pixel is compared with the two pixels of the same colour on its own line, at positions two to the left and two to the right. A pixel that stands out by more than a programmable margin from both of them, either above both or below both, is judged defective. Its value is then replaced by the rounded mean of those two neighbours.

Detection is made afresh for every pixel, so there is no table of known bad locations and no limit on how many pixels can be repaired in a frame. The window always holds the raw, uncorrected samples. A pixel therefore never uses an already repaired neighbour.

A pixel enters with a valid flag and a start-of-line flag. The samples of one line arrive on consecutive clock cycles, and a cycle without valid ends the line. The output appears exactly two clock cycles later, with its flags delayed to match. A single enable input turns the correction off. The stream then passes unchanged with the same timing.

Top module: `bayer_dpc`

## Requirements
- R1: `px_out_vld` and `px_out_sol` equal `px_in_vld` and `px_in_vld & px_in_sol` from two clock cycles earlier. When it is not corrected, `px_out` equals `px_in` from two cycles earlier.
- R2: A pixel is hot when its value C satisfies C > L + T and C > R + T, with L and R its same-colour neighbours at offsets −2 and +2 on the line and T = `dpc_thresh`. A hot pixel is output as the neighbour mean.
- R3: A pixel is cold when C + T < L and C + T < R. A cold pixel is output as the neighbour mean.
- R4: The comparisons are strict, so a difference equal to T is not corrected. A pixel that is hot or cold against only one neighbour is not corrected. A threshold of 0 corrects any pixel that is strictly above both neighbours or strictly below both.
- R5: The neighbour mean is (L + R + 1) >> 1, computed on an 11-bit sum with no overflow. For example, 1023 and 1022 give 1023, and 0 and 1 give 1.
- R6: While `dpc_en` is 0 during the output cycle, every pixel leaves unchanged, with the same two-cycle latency.
- R7: The first two and the last two pixels of a line are never corrected, because one neighbour is missing. The same holds for pixels next to a gap in valid, since a gap ends the line.
- R8: Correction decisions use raw input samples only. Any number of defects in a line are each repaired, with nothing stored between lines.
- R9: While reset (`rst_n` = 0) is asserted, `px_out_vld` and `px_out_sol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_in_vld | input | 1 | Input sample valid |
| px_in_sol | input | 1 | First sample of a line (meaningful with valid) |
| px_in | input | 10 | Raw Bayer sample |
| dpc_en | input | 1 | Correction enable |
| dpc_thresh | input | 10 | Detection margin T |
| px_out_vld | output | 1 | Output sample valid |
| px_out_sol | output | 1 | Output first sample of a line |
| px_out | output | 10 | Corrected or passed sample |

## Verification
Single hot and cold spikes on a flat two-colour line show that both directions are detected and that the replacement uses the −2/+2 samples rather than the adjacent ones of the other colour. Margins equal to the threshold, one-sided outliers and a zero threshold mark the strict edge of detection. Near-full-scale neighbours confirm the rounding and the 11-bit sum. Spikes at both ends of lines, lines broken by valid gaps and lines that start back to back separate the line-boundary pass-through from ordinary timing. Dense defect rows show that only raw neighbours are used, and the same spike with the enable off shows a clean bypass.

// File: rtl/bayer_dpc.sv
module bayer_dpc #(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             px_in_vld,
  input  logic             px_in_sol,
  input  logic [PIX_W-1:0] px_in,
  input  logic             dpc_en,
  input  logic [PIX_W-1:0] dpc_thresh,
  output logic             px_out_vld,
  output logic             px_out_sol,
  output logic [PIX_W-1:0] px_out
);
  localparam int SUM_W = PIX_W + 1;
  localparam int DEPTH = 4;

  logic [PIX_W-1:0] pix_q [1:DEPTH];
  logic [DEPTH:1]   vld_q;
  logic [DEPTH:1]   sol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      sol_q <= '0;
      for (int i = 1; i <= DEPTH; i++) pix_q[i] <= '0;
    end else begin
      vld_q <= {vld_q[DEPTH-1:1], px_in_vld};
      sol_q <= {sol_q[DEPTH-1:1], px_in_vld & px_in_sol};
      pix_q[1] <= px_in;
      for (int i = 2; i <= DEPTH; i++) pix_q[i] <= pix_q[i-1];
    end
  end

  logic left_ok, right_ok, hot, cold, fix;
  logic [SUM_W-1:0] c_x, l_x, r_x, t_x, sum_x;

  assign left_ok  = vld_q[4] & vld_q[3] & vld_q[2] & ~sol_q[2] & ~sol_q[3];
  assign right_ok = px_in_vld & vld_q[1] & ~px_in_sol & ~sol_q[1];

  assign c_x = {1'b0, pix_q[2]};
  assign l_x = {1'b0, pix_q[4]};
  assign r_x = {1'b0, px_in};
  assign t_x = {1'b0, dpc_thresh};

  assign hot   = (c_x > l_x + t_x) && (c_x > r_x + t_x);
  assign cold  = (c_x + t_x < l_x) && (c_x + t_x < r_x);
  assign sum_x = l_x + r_x + SUM_W'(1);
  assign fix   = dpc_en & vld_q[2] & left_ok & right_ok & (hot | cold);

  assign px_out_vld = vld_q[2];
  assign px_out_sol = sol_q[2];
  assign px_out     = fix ? sum_x[SUM_W-1:1] : pix_q[2];

  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd2) |-> (px_out_vld == $past(px_in_vld, 2))); // R1
  AST_SOL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd2) |-> (px_out_sol == ($past(px_in_vld, 2) & $past(px_in_sol, 2)))); // R1
  AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd2 && !dpc_en && px_out_vld) |-> (px_out == $past(px_in, 2))); // R6
  AST_LINE_START_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd2 && px_out_sol) |-> (px_out == $past(px_in, 2))); // R7
  AST_MEAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 3'd4 && px_out_vld && px_out != $past(px_in, 2)) |->
      ((px_out >= $past(px_in, 4) || px_out >= px_in) &&
       (px_out <= $past(px_in, 4) || px_out <= px_in))); // R2
endmodule

// File: tb/sim_bayer_dpc.sv
module sim_bayer_dpc;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       px_in_vld = 0, px_in_sol = 0, dpc_en = 1;
  logic [9:0] px_in = '0, dpc_thresh = 10'd20;
  logic       px_out_vld, px_out_sol;
  logic [9:0] px_out;

  bayer_dpc u0 (.clk(clk), .rst_n(rst_n), .px_in_vld(px_in_vld), .px_in_sol(px_in_sol),
    .px_in(px_in), .dpc_en(dpc_en), .dpc_thresh(dpc_thresh),
    .px_out_vld(px_out_vld), .px_out_sol(px_out_sol), .px_out(px_out));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, ticks = 0;
  bit hv [0:4095];
  bit hs [0:4095];
  int hp [0:4095];

  task automatic report(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at step %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input bit s, input int p, input string tag);
    int k, ev, es, ep, l, r, th;
    bit lok, rok;
    @(negedge clk);
    px_in_vld = v; px_in_sol = s; px_in = p[9:0];
    hv[cyc] = v; hs[cyc] = v & s; hp[cyc] = p;
    #1;
    k = cyc - 2;
    ev = 0; es = 0; ep = 0;
    if (k >= 0) begin
      ev = hv[k]; es = hs[k]; ep = hp[k];
      lok = (k >= 2) && hv[k-2] && hv[k-1] && !hs[k] && !hs[k-1];
      rok = hv[k+1] && hv[k+2] && !hs[k+1] && !hs[k+2];
      th = dpc_thresh;
      if (dpc_en && ev != 0 && lok && rok) begin
        l = hp[k-2]; r = hp[k+2];
        if ((ep > l + th && ep > r + th) || (ep + th < l && ep + th < r))
          ep = (l + r + 1) / 2;
      end
    end
    checks++;
    if (px_out_vld !== ev[0] || px_out_sol !== es[0] || (ev != 0 && int'(px_out) != ep)) begin
      fails++;
      $display("FAIL %s actual=v%0d s%0d p%0d expected=v%0d s%0d p%0d at step %0d",
               tag, px_out_vld, px_out_sol, px_out, ev, es, ep, cyc);
    end
    cyc++;
  endtask

  task automatic line(input string tag, input int px[]);
    foreach (px[i]) step(1'b1, i == 0, px[i], tag);
  endtask

  task automatic blank(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      ticks++;
      if (ticks > 50000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int px[];
    repeat (3) @(posedge clk);
    @(negedge clk);
    report("R9 reset valid", int'(px_out_vld), 0);
    report("R9 reset sol", int'(px_out_sol), 0);
    rst_n = 1;

    blank(3, "R1");
    dpc_en = 1; dpc_thresh = 10'd20;
    line("R2", '{100,200,100,200,500,200,100,200,100,200});
    report("R2 last spike left input", 1, 1);
    blank(3, "R2");
    line("R3", '{600,300,600,300,50,300,600,300,600,300,600,30,600,300});
    blank(3, "R3");
    dpc_thresh = 10'd30;
    line("R4", '{100,100,100,100,130,100,100,100,131,100,100,100,170,100,200,100});
    blank(3, "R4");
    dpc_thresh = 10'd0;
    line("R4", '{50,50,50,50,51,50,50,50,50,50,49,50,50});
    blank(3, "R4");
    line("R5", '{1023,0,1023,0,0,0,1022,0,1023,0,0,0,1023,0,1,0,0});
    blank(3, "R5");
    dpc_en = 0; dpc_thresh = 10'd20;
    line("R6", '{100,200,100,200,900,200,100,200,5,200,100,200});
    blank(3, "R6");
    dpc_en = 1;
    line("R7", '{900,900,100,100,100,100,100,100,900,900});
    blank(2, "R7");
    line("R7", '{100,100,100,100});
    step(1'b0, 1'b0, 0, "R7");
    step(1'b1, 1'b0, 900, "R7");
    step(1'b1, 1'b0, 100, "R7");
    step(1'b1, 1'b0, 100, "R7");
    blank(3, "R7");
    px = new[24];
    foreach (px[i]) px[i] = (i % 4 == 2) ? 900 : 100;
    line("R8", px);
    foreach (px[i]) px[i] = (i % 2 == 0) ? 1000 : 10;
    line("R8", px);
    blank(3, "R8");
    for (int n = 0; n < 6; n++) begin
      px = new[8 + n * 5];
      foreach (px[i]) px[i] = (i * 37 + n * 211 + 11) % 1024;
      dpc_thresh = 10'(n * 40);
      line("R1", px);
      if (n % 2 == 1) blank(n, "R1");
    end
    blank(4, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule